// File: doc/BRIEF.md
# Power Mode and Wakeup Controller

This block manages the sleep states of a small 8-bit microcontroller. Software writes one control register to put the core into a light sleep or a deep sleep. The block then drops the enable of the system clock, and in deep sleep the enable of the 32 kHz RC clock as well. Wakeup sources are watched from a free-running supervisory clock. When one of them fires, the clocks come back and hardware clears the sleep bits. The two depths differ both in the wakeup sources they accept and in which bits are cleared on exit.

The same register switches the low-voltage detector on and reports its flag. The flag is held at zero until a settle window after the enabling write has passed. The block also merges every reset source into one system reset. That reset asserts at once and releases in step with the clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The control register is at address 0. Bit 7 is the low-voltage flag (read-only), bit 6 is the detector enable, bit 4 is the deep-sleep bit and bit 0 is the light-sleep bit. Bits 5, 3, 2 and 1 read 0, and any other address reads 0.
- R2: In run mode, a write with bit 0 set and bit 4 clear enters light sleep. From the next cycle, sys_clk_en is 0 and rc_clk_en stays 1.
- R3: In run mode, a write with bit 4 set enters deep sleep, even if bit 0 is also set. From the next cycle, both clock enables are 0, and both written bits read back as written.
- R4: In light sleep, a timer overflow pulse, ext_int_n low, or a change on any pin of port A or port B brings sys_clk_en back to 1 after the third rising edge that follows the input change.
- R5: Leaving light sleep clears bit 0 and leaves bit 4 unchanged.
- R6: In deep sleep, a timer overflow has no effect. ext_int_n low or a pin change wakes the block with the same latency as in R4 and clears both bit 0 and bit 4.
- R7: The reference for pin-change detection is the synchronized port value captured on the entry write. A port value that changed before entry does not wake the block.
- R8: While asleep, bus writes are ignored, and the register keeps its value.
- R9: lv_det_en follows bit 6. After a write that sets bit 6 from 0, bit 7 reads 0 for SETTLE_CYC (default 2) cycles. After that it reads the detector input, which is synchronized through two flops and registered once.
- R10: sys_rst_n goes low at once when por_n is low, illegal_addr is high, wdt_ovf is high or brownout is high. It goes low two edges after rst_pin_n goes low. It returns high on the second edge after all sources are clear; for the pin, this is the fourth edge after rst_pin_n rises.
- R11: After reset the register reads 0, both clock enables are 1 and lv_det_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running supervisory clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low |
| illegal_addr | input | 1 | Illegal address event, active high |
| wdt_ovf | input | 1 | Watchdog overflow, active high |
| brownout | input | 1 | Supply below minimum, from the comparator |
| timer_ovf | input | 1 | Timer overflow pulse |
| ext_int_n | input | 1 | External interrupt, active low |
| port_a | input | PA_W | Port A pin levels |
| port_b | input | PB_W | Port B pin levels |
| lv_det_in | input | 1 | Low-voltage detector output |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| sys_clk_en | output | 1 | System clock enable |
| rc_clk_en | output | 1 | RC clock enable |
| lv_det_en | output | 1 | Low-voltage detector enable |
| sys_rst_n | output | 1 | Combined system reset, active low |

## Verification
Mode entry shows on the clock enables one edge after the write. A wakeup shows three edges after the source input changes: two synchronizer flops, then the mode register. The low-voltage flag first reflects the detector SETTLE_CYC+1 edges after the enabling write. Reset asserts without an edge, except for the pin, which takes two edges; release takes two edges, four for the pin. The bench drives inputs on falling edges and counts rising edges to each due point. It samples a cycle early to see the old value and at the due cycle to see the new one.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_LIGHT = 2'd1,
    MODE_DEEP  = 2'd2
  } pwr_mode_e;

  localparam int BIT_LVF   = 7;
  localparam int BIT_DET   = 6;
  localparam int BIT_DEEP  = 4;
  localparam int BIT_LIGHT = 0;

  // deep sleep wins when both sleep bits are written
  function automatic pwr_mode_e entry_mode(input logic [7:0] wd);
    if (wd[BIT_DEEP])       return MODE_DEEP;
    else if (wd[BIT_LIGHT]) return MODE_LIGHT;
    else                    return MODE_RUN;
  endfunction

  function automatic logic wake_hit(input pwr_mode_e m, input logic tmr,
                                    input logic intr, input logic pinchg);
    case (m)
      MODE_LIGHT: return tmr | intr | pinchg;
      MODE_DEEP:  return intr | pinchg;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] pack_ctrl(input logic lvf, input logic det,
                                           input logic deep, input logic light);
    logic [7:0] r;
    r = '0;
    r[BIT_LVF]   = lvf;
    r[BIT_DET]   = det;
    r[BIT_DEEP]  = deep;
    r[BIT_LIGHT] = light;
    return r;
  endfunction
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pwr_pin_watch.sv
module pwr_pin_watch #(
  parameter int PA_W = 8,
  parameter int PB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] pa,
  input  logic [PB_W-1:0] pb,
  input  logic            snap,
  output logic            pin_chg
);
  localparam int W = PA_W + PB_W;

  logic [W-1:0] cur;
  logic [W-1:0] ref_q;
  logic [W-1:0] diff;

  pwr_sync #(.W(W), .RST_VAL('0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pb, pa}), .q(cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ref_q <= '0;
    else if (snap) ref_q <= cur;
  end

  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign diff[i] = cur[i] ^ ref_q[i];
  end

  assign pin_chg = |diff;
endmodule

// File: rtl/pwr_rst_combine.sv
module pwr_rst_combine (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic illegal_addr,
  input  logic wdt_ovf,
  input  logic brownout,
  output logic raw_rst,
  output logic sys_rst_n
);
  logic [1:0] pin_q;
  logic [1:0] rel_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pin_q <= 2'b00;
    else        pin_q <= {pin_q[0], rst_pin_n};
  end

  assign raw_rst = !por_n || !pin_q[1] || illegal_addr || wdt_ovf || brownout;

  always_ff @(posedge clk or posedge raw_rst) begin
    if (raw_rst) rel_q <= 2'b00;
    else         rel_q <= {rel_q[0], 1'b1};
  end

  assign sys_rst_n = rel_q[1];
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PA_W       = 8,
  parameter int PB_W       = 8,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic              illegal_addr,
  input  logic              wdt_ovf,
  input  logic              brownout,
  input  logic              timer_ovf,
  input  logic              ext_int_n,
  input  logic [PA_W-1:0]   port_a,
  input  logic [PB_W-1:0]   port_b,
  input  logic              lv_det_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sys_clk_en,
  output logic              rc_clk_en,
  output logic              lv_det_en,
  output logic              sys_rst_n
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic raw_rst;
  logic [1:0] ev_s;
  logic det_s;
  logic pin_chg;
  logic wake_evt;
  logic ctrl_wr;
  logic snap;
  logic lv_valid;

  pwr_mode_e        mode_q;
  logic             reg_halt, reg_stop, reg_det, lvflag_q;
  logic [CNT_W-1:0] settle_q;

  pwr_rst_combine u_rst (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
    .illegal_addr(illegal_addr), .wdt_ovf(wdt_ovf), .brownout(brownout),
    .raw_rst(raw_rst), .sys_rst_n(sys_rst_n)
  );

  // ev_s[1] is the interrupt line, idle high
  pwr_sync #(.W(2), .RST_VAL(2'b10)) u_ev (
    .clk(clk), .rst_n(sys_rst_n), .d({ext_int_n, timer_ovf}), .q(ev_s)
  );

  pwr_sync #(.W(1), .RST_VAL(1'b0)) u_det (
    .clk(clk), .rst_n(sys_rst_n), .d(lv_det_in), .q(det_s)
  );

  assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR) && (mode_q == MODE_RUN);
  assign snap    = ctrl_wr && (entry_mode(bus_wdata) != MODE_RUN);

  pwr_pin_watch #(.PA_W(PA_W), .PB_W(PB_W)) u_pin (
    .clk(clk), .rst_n(sys_rst_n), .pa(port_a), .pb(port_b),
    .snap(snap), .pin_chg(pin_chg)
  );

  assign wake_evt = wake_hit(mode_q, ev_s[0], !ev_s[1], pin_chg);
  assign lv_valid = reg_det && (settle_q == '0);

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      mode_q   <= MODE_RUN;
      reg_halt <= 1'b0;
      reg_stop <= 1'b0;
      reg_det  <= 1'b0;
      settle_q <= '0;
      lvflag_q <= 1'b0;
    end else begin
      lvflag_q <= lv_valid && det_s;
      if (ctrl_wr) begin
        reg_halt <= bus_wdata[BIT_LIGHT];
        reg_stop <= bus_wdata[BIT_DEEP];
        reg_det  <= bus_wdata[BIT_DET];
        mode_q   <= entry_mode(bus_wdata);
      end else if (wake_evt) begin
        mode_q   <= MODE_RUN;
        reg_halt <= 1'b0;
        if (mode_q == MODE_DEEP) reg_stop <= 1'b0;
      end
      if (ctrl_wr && bus_wdata[BIT_DET] && !reg_det) settle_q <= CNT_W'(SETTLE_CYC);
      else if (settle_q != '0)                       settle_q <= settle_q - 1'b1;
    end
  end

  assign sys_clk_en = (mode_q == MODE_RUN);
  assign rc_clk_en  = (mode_q != MODE_DEEP);
  assign lv_det_en  = reg_det;
  assign bus_rdata  = (bus_addr == CTRL_ADDR) ?
                      pack_ctrl(lvflag_q, reg_det, reg_stop, reg_halt) : 8'h00;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              raw_rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              sys_clk_en,
  input logic              rc_clk_en,
  input logic              wake_evt,
  input logic              reg_halt,
  input logic              reg_stop,
  input logic              lv_det_en,
  input logic              lvflag_q
);
  a_r2_light_entry: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (bus_wr && bus_addr == '0 && bus_wdata[0] && !bus_wdata[4] && sys_clk_en)
      |=> (!sys_clk_en && rc_clk_en));

  a_r3_deep_entry: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (bus_wr && bus_addr == '0 && bus_wdata[4] && sys_clk_en)
      |=> (!sys_clk_en && !rc_clk_en));

  a_r4_wake_resumes: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!sys_clk_en && wake_evt) |=> sys_clk_en);

  a_r5_light_clear: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!sys_clk_en && rc_clk_en && wake_evt) |=> (!reg_halt && $stable(reg_stop)));

  a_r6_deep_clear: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!rc_clk_en && wake_evt) |=> (!reg_halt && !reg_stop));

  a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!sys_clk_en && !wake_evt) |=> $stable({reg_halt, reg_stop, lv_det_en}));

  a_r9_flag_gated: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !lv_det_en |=> !lvflag_q);

  a_r10_clean_release: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> (!raw_rst && !$past(raw_rst)));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .raw_rst(raw_rst),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .sys_clk_en(sys_clk_en), .rc_clk_en(rc_clk_en), .wake_evt(wake_evt),
  .reg_halt(reg_halt), .reg_stop(reg_stop), .lv_det_en(lv_det_en),
  .lvflag_q(lvflag_q)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_pin_n = 1'b1, illegal_addr = 1'b0, wdt_ovf = 1'b0;
  logic brownout = 1'b0, timer_ovf = 1'b0, ext_int_n = 1'b1, lv_det_in = 1'b0;
  logic [7:0] port_a = 8'h00, port_b = 8'h00;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic sys_clk_en, rc_clk_en, lv_det_en, sys_rst_n;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .illegal_addr(illegal_addr),
    .wdt_ovf(wdt_ovf), .brownout(brownout), .timer_ovf(timer_ovf),
    .ext_int_n(ext_int_n), .port_a(port_a), .port_b(port_b),
    .lv_det_in(lv_det_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_clk_en(sys_clk_en),
    .rc_clk_en(rc_clk_en), .lv_det_en(lv_det_en), .sys_rst_n(sys_rst_n)
  );

  // {wdata[7:0], source[2:0], expect_wake}; source 0 timer, 2 interrupt, 3 port A, 4 port B
  localparam logic [11:0] VEC [10] = '{
    {8'h01, 3'd0, 1'b1}, {8'h01, 3'd2, 1'b1}, {8'h01, 3'd3, 1'b1},
    {8'h01, 3'd4, 1'b1}, {8'h10, 3'd0, 1'b0}, {8'h10, 3'd2, 1'b1},
    {8'h10, 3'd3, 1'b1}, {8'h10, 3'd4, 1'b1}, {8'h11, 3'd0, 1'b0},
    {8'h11, 3'd3, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
  endtask

  task automatic wake_by_int();
    ext_int_n = 1'b0;
    edges(4);
    ext_int_n = 1'b1;
    edges(4);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    edges(3);
    por_n = 1'b1;
    edges(3);
    chk("R10 release not before fourth edge", sys_rst_n, 0);
    edges(1);
    chk("R10 release after por", sys_rst_n, 1);
    chk("R11 reg after reset", bus_rdata, 8'h00);
    chk("R11 clocks after reset", {sys_clk_en, rc_clk_en, lv_det_en}, 3'b110);

    // R1 layout and unused bits
    wr(8'h00, 8'hEE);
    chk("R1 unused bits read 0", bus_rdata, 8'h40);
    bus_addr = 8'h05; #1;
    chk("R1 other address reads 0", bus_rdata, 8'h00);
    bus_addr = 8'h00;
    chk("R9 enable follows bit 6", lv_det_en, 1);
    wr(8'h00, 8'h00);

    // R9 settle window
    lv_det_in = 1'b1;
    edges(4);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'h40;
    edges(1);
    bus_wr = 1'b0; bus_wdata = 8'h00;
    chk("R9 flag masked w+1", bus_rdata[7], 0);
    edges(1);
    chk("R9 flag masked w+2", bus_rdata[7], 0);
    edges(1);
    chk("R9 flag masked w+3", bus_rdata[7], 0);
    edges(1);
    chk("R9 flag valid", bus_rdata[7], 1);
    lv_det_in = 1'b0;
    edges(3);
    chk("R9 flag follows detector", bus_rdata[7], 0);
    wr(8'h00, 8'h00);

    // table of wake vectors
    for (int i = 0; i < 10; i++) begin
      logic [11:0] v;
      v = VEC[i];
      wr(8'h00, v[11:4]);
      chk("R2 R3 clocks on entry", {sys_clk_en, rc_clk_en}, {1'b0, !v[8]});
      chk("R3 bits on entry", bus_rdata, {3'b000, v[8], 3'b000, v[4]});
      case (v[3:1])
        3'd0: timer_ovf = 1'b1;
        3'd2: ext_int_n = 1'b0;
        3'd3: port_a = port_a ^ (8'h01 << (i % 8));
        default: port_b = port_b ^ (8'h80 >> (i % 8));
      endcase
      edges(1);
      timer_ovf = 1'b0;
      edges(1);
      chk("R4 not yet awake", sys_clk_en, 0);
      edges(1);
      chk("R4 R6 wake outcome", sys_clk_en, v[0]);
      if (v[0]) chk("R5 R6 bits after wake", bus_rdata, 8'h00);
      else begin
        chk("R6 timer ignored in deep", bus_rdata, {3'b000, v[8], 3'b000, v[4]});
        ext_int_n = 1'b0;
        edges(3);
        chk("R6 interrupt wakes deep", {sys_clk_en, bus_rdata}, 9'h100);
      end
      ext_int_n = 1'b1;
      edges(4);
    end

    // R7 change before entry is the new reference
    port_a = port_a ^ 8'h10;
    edges(4);
    wr(8'h00, 8'h01);
    edges(5);
    chk("R7 earlier change ignored", sys_clk_en, 0);
    // R8 write while asleep ignored
    wr(8'h00, 8'h40);
    chk("R8 write ignored", {lv_det_en, bus_rdata}, 9'h001);
    wake_by_int();
    chk("R5 halt cleared", bus_rdata, 8'h00);

    // R10 reset pin
    rst_pin_n = 1'b0;
    edges(1);
    chk("R10 pin one edge", sys_rst_n, 1);
    edges(1);
    chk("R10 pin two edges", sys_rst_n, 0);
    rst_pin_n = 1'b1;
    edges(3);
    chk("R10 pin release 3", sys_rst_n, 0);
    edges(1);
    chk("R10 pin release 4", sys_rst_n, 1);

    // R10 illegal address, asynchronous
    wr(8'h00, 8'h40);
    illegal_addr = 1'b1; #1;
    chk("R10 illegal asserts at once", sys_rst_n, 0);
    chk("R10 reg cleared", bus_rdata, 8'h00);
    @(negedge clk);
    illegal_addr = 1'b0;
    edges(1);
    chk("R10 illegal release 1", sys_rst_n, 0);
    edges(1);
    chk("R10 illegal release 2", sys_rst_n, 1);

    // R10 watchdog in deep sleep
    wr(8'h00, 8'h10);
    wdt_ovf = 1'b1; #1;
    chk("R10 watchdog asserts", sys_rst_n, 0);
    @(negedge clk);
    wdt_ovf = 1'b0;
    edges(2);
    chk("R10 R11 after watchdog", {sys_rst_n, sys_clk_en, rc_clk_en, bus_rdata}, 11'h700);

    // R10 brownout
    brownout = 1'b1; #1;
    chk("R10 brownout asserts", sys_rst_n, 0);
    @(negedge clk);
    brownout = 1'b0;
    edges(2);
    chk("R10 brownout release", sys_rst_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule